// File: doc/BRIEF.md
# Row-Sequential Pixel Matrix Controller

This block drives the row lines of a pixel matrix that is read one row at a time. Every row channel has two logic-level outputs: a gate line that turns on the pixel amplifiers of that row, and a clear line that empties the row's stored charge. A frame runs from the edge row chosen by a direction input to the opposite edge. For each row it steps through a fixed order: gate on and settle, first (signal) sample window, clear pulse, second (baseline) sample window, then gate off for a gap. It then moves to the next row.

The sample-window strobes and the current row number are provided as outputs, so that a downstream sampling block can take the difference between the two samples. The length of each phase is a programmable cycle count. The phase lengths can be written only while the controller is idle. Two timing modes are available. In the internal mode, the block's own counter ends each phase. In the direct mode, phases advance only on an external step strobe, and the order is kept the same. For tall arrays, several controllers can be chained. When a controller finishes its last row, it either raises a frame-complete pulse or passes a token to the next controller.

Top module: `rowseq_ctrl`

## Requirements
- R1: After reset, all gate and clear outputs, both sample strobes, busy, frame_done and chain_out are low, and row_idx is 0. All four phase lengths reset to 0.
- R2: At most one gate output is high at any time, and it is the one whose index equals row_idx. A clear output is high only on the row whose gate output is high.
- R3: Within a row, the phases come in this order: settle (gate on), pre-sample (gate on, sample_pre high), clear (gate and clear on), post-sample (gate on, sample_post high), gap (all gates off). In the internal mode, a phase whose configured length is L lasts L+1 cycles. The configuration selector codes are 0 = settle, 1 = both sample windows, 2 = clear, 3 = gap.
- R4: With dir_down = 0, a frame starts at row 0 and ascends to row ROWS-1. With dir_down = 1, it starts at row ROWS-1 and descends to row 0. Direction, mode and chain_en are sampled when the frame starts. row_idx holds the current row in all of its phases, including the gap.
- R5: A start or chain_in pulse while idle begins a frame. The outputs show the first row's settle phase in the cycle after the clock edge that captured the pulse.
- R6: After the gap of the final row, busy falls. In that same cycle, frame_done pulses for one cycle if chain_en was 0, or chain_out pulses for one cycle if chain_en was 1. The two never pulse together.
- R7: While busy, configuration writes are ignored, and start and chain_in are ignored.
- R8: In the direct mode, the current phase holds for as long as ext_step is low. Each cycle in which ext_step is high moves the controller to the next phase, in the same order as in R3.
- R9: sample_pre and sample_post are never high together, and each is high only while a gate output is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame when idle |
| chain_in | input | 1 | Token from the previous controller; begins a frame when idle |
| dir_down | input | 1 | Scan direction: 0 ascending, 1 descending |
| chain_en | input | 1 | 1: hand off to the next controller at end of frame |
| mode_direct | input | 1 | 1: phases advance on ext_step |
| ext_step | input | 1 | External phase-advance strobe used in the direct mode |
| cfg_we | input | 1 | Phase-length write enable (idle only) |
| cfg_sel | input | 2 | Phase-length selector |
| cfg_data | input | CNT_W | Phase length value |
| gate_on | output | ROWS | Per-row gate line |
| clear_on | output | ROWS | Per-row clear line |
| sample_pre | output | 1 | Signal sample window |
| sample_post | output | 1 | Baseline sample window |
| row_idx | output | clog2(ROWS) | Current row |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at the end of a frame with no hand-off |
| chain_out | output | 1 | One-cycle token to the next controller |

## Verification
The bench builds the block with ROWS = 6 and CNT_W = 4. With only six rows, both edge rows, the turn at the last row and the hand-off pulse are all reached within a frame of a few dozen cycles. Both directions and both end-of-frame outcomes can therefore be compared cycle by cycle. The 4-bit count width still allows unequal, multi-cycle phase lengths, so swapped or shortened phases show up as shifted strobes.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_PRE    = 3'd2,
    PH_CLR    = 3'd3,
    PH_POST   = 3'd4,
    PH_GAP    = 3'd5
  } phase_t;

  localparam int NUM_LEN = 4;
  localparam logic [1:0] SEL_SETTLE = 2'd0;
  localparam logic [1:0] SEL_SAMPLE = 2'd1;
  localparam logic [1:0] SEL_CLEAR  = 2'd2;
  localparam logic [1:0] SEL_GAP    = 2'd3;
endpackage

// File: rtl/rowseq_timer.sv
module rowseq_timer
  import rowseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase,
  input  logic             direct,
  input  logic             ext_step,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_data,
  output logic             step
);
  logic [NUM_LEN-1:0][CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_len;
  logic idle;

  assign idle = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (idle && cfg_we) begin
      len_q[cfg_sel] <= cfg_data;
    end
  end

  always_comb begin
    unique case (phase)
      PH_SETTLE:       cur_len = len_q[SEL_SETTLE];
      PH_PRE, PH_POST: cur_len = len_q[SEL_SAMPLE];
      PH_CLR:          cur_len = len_q[SEL_CLEAR];
      PH_GAP:          cur_len = len_q[SEL_GAP];
      default:         cur_len = '0;
    endcase
  end

  assign step = !idle && (direct ? ext_step : (cnt_q == cur_len));

  always_ff @(posedge clk) begin
    if (rst || idle || step) cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  // R7
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle && cfg_we) |=> $stable(len_q));
endmodule

// File: rtl/rowseq_fsm.sv
module rowseq_fsm
  import rowseq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             chain_in,
  input  logic             dir_down,
  input  logic             chain_en,
  input  logic             mode_direct,
  input  logic             step,
  output phase_t           phase,
  output logic [ROW_W-1:0] row,
  output logic             direct_q,
  output logic             frame_done,
  output logic             chain_out
);
  localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(ROWS - 1);

  logic dir_q, chain_q, last_row;

  assign last_row = dir_q ? (row == '0) : (row == TOP_ROW);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      row        <= '0;
      dir_q      <= 1'b0;
      direct_q   <= 1'b0;
      chain_q    <= 1'b0;
      frame_done <= 1'b0;
      chain_out  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      chain_out  <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start || chain_in) begin
          phase    <= PH_SETTLE;
          dir_q    <= dir_down;
          direct_q <= mode_direct;
          chain_q  <= chain_en;
          row      <= dir_down ? TOP_ROW : '0;
        end
        PH_SETTLE: if (step) phase <= PH_PRE;
        PH_PRE:    if (step) phase <= PH_CLR;
        PH_CLR:    if (step) phase <= PH_POST;
        PH_POST:   if (step) phase <= PH_GAP;
        PH_GAP: if (step) begin
          if (last_row) begin
            phase      <= PH_IDLE;
            frame_done <= !chain_q;
            chain_out  <= chain_q;
          end else begin
            phase <= PH_SETTLE;
            row   <= dir_q ? row - ROW_W'(1) : row + ROW_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4
  row_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE && row != $past(row))
      |-> (row == $past(row) + ROW_W'(1) || row == $past(row) - ROW_W'(1)));
endmodule

// File: rtl/rowseq_decode.sv
module rowseq_decode
  import rowseq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  phase_t           phase,
  input  logic [ROW_W-1:0] row,
  output logic [ROWS-1:0]  gate_on,
  output logic [ROWS-1:0]  clear_on
);
  logic gate_phase, clr_phase;

  assign gate_phase = (phase == PH_SETTLE) || (phase == PH_PRE) ||
                      (phase == PH_CLR) || (phase == PH_POST);
  assign clr_phase  = (phase == PH_CLR);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic hit;
    assign hit         = (row == ROW_W'(i));
    assign gate_on[i]  = gate_phase && hit;
    assign clear_on[i] = clr_phase && hit;
  end
endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    chain_in,
  input  logic                    dir_down,
  input  logic                    chain_en,
  input  logic                    mode_direct,
  input  logic                    ext_step,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [CNT_W-1:0]        cfg_data,
  output logic [ROWS-1:0]         gate_on,
  output logic [ROWS-1:0]         clear_on,
  output logic                    sample_pre,
  output logic                    sample_post,
  output logic [$clog2(ROWS)-1:0] row_idx,
  output logic                    busy,
  output logic                    frame_done,
  output logic                    chain_out
);
  localparam int ROW_W = $clog2(ROWS);

  phase_t phase;
  logic step, direct_q;

  rowseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .phase(phase), .direct(direct_q),
    .ext_step(ext_step), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .step(step)
  );

  rowseq_fsm #(.ROWS(ROWS), .ROW_W(ROW_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .chain_in(chain_in),
    .dir_down(dir_down), .chain_en(chain_en), .mode_direct(mode_direct),
    .step(step), .phase(phase), .row(row_idx), .direct_q(direct_q),
    .frame_done(frame_done), .chain_out(chain_out)
  );

  rowseq_decode #(.ROWS(ROWS), .ROW_W(ROW_W)) u_dec (
    .phase(phase), .row(row_idx), .gate_on(gate_on), .clear_on(clear_on)
  );

  assign sample_pre  = (phase == PH_PRE);
  assign sample_post = (phase == PH_POST);
  assign busy        = (phase != PH_IDLE);

  // R2
  one_row_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_on));
  // R2
  clr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (|clear_on) |-> ((clear_on & gate_on) == clear_on));
  // R9
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_pre || sample_post) |-> ((|gate_on) && !(sample_pre && sample_post)));
  // R3
  gap_before_move_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && row_idx != $past(row_idx)) |-> ($past(gate_on) == '0));
  // R6
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done || chain_out) |-> (!busy && !(frame_done && chain_out)));
endmodule

// File: tb/rowseq_ctrl_test.sv
`timescale 1ns/1ps
module rowseq_ctrl_test;
  localparam int ROWS  = 6;
  localparam int CNT_W = 4;
  localparam int RW    = $clog2(ROWS);

  logic clk = 0, rst = 1;
  logic start = 0, chain_in = 0, dir_down = 0, chain_en = 0;
  logic mode_direct = 0, ext_step = 0, cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [CNT_W-1:0] cfg_data = 0;
  logic [ROWS-1:0] gate_on, clear_on;
  logic sample_pre, sample_post, busy, frame_done, chain_out;
  logic [RW-1:0] row_idx;

  int total = 0, bad = 0;

  typedef struct {int row; bit gate; bit clr; bit pre; bit post;} exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rowseq_ctrl #(.ROWS(ROWS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .start(start), .chain_in(chain_in),
    .dir_down(dir_down), .chain_en(chain_en), .mode_direct(mode_direct),
    .ext_step(ext_step), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .gate_on(gate_on), .clear_on(clear_on),
    .sample_pre(sample_pre), .sample_post(sample_post), .row_idx(row_idx),
    .busy(busy), .frame_done(frame_done), .chain_out(chain_out)
  );

  task automatic chk(string req, bit ok, string act, string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic push_n(int n, int r, bit g, bit c, bit p, bit s);
    for (int i = 0; i < n; i++) q.push_back('{r, g, c, p, s});
  endtask

  // expected per-cycle trace of one internal-mode frame
  task automatic build(bit down, int ls, int lsm, int lc, int lg);
    for (int k = 0; k < ROWS; k++) begin
      int r = down ? ROWS - 1 - k : k;
      push_n(ls + 1,  r, 1, 0, 0, 0);
      push_n(lsm + 1, r, 1, 0, 1, 0);
      push_n(lc + 1,  r, 1, 1, 0, 0);
      push_n(lsm + 1, r, 1, 0, 0, 1);
      push_n(lg + 1,  r, 0, 0, 0, 0);
    end
  endtask

  task automatic cmp(string req, exp_t e);
    logic [ROWS-1:0] eg, ec;
    bit ok;
    eg = e.gate ? (ROWS'(1) << e.row) : '0;
    ec = e.clr  ? (ROWS'(1) << e.row) : '0;
    ok = (gate_on == eg) && (clear_on == ec) && (sample_pre == e.pre) &&
         (sample_post == e.post) && (int'(row_idx) == e.row) && busy;
    chk(req, ok,
        $sformatf("g=%b c=%b pre=%0b post=%0b row=%0d busy=%0b",
                  gate_on, clear_on, sample_pre, sample_post, row_idx, busy),
        $sformatf("g=%b c=%b pre=%0b post=%0b row=%0d busy=1",
                  eg, ec, e.pre, e.post, e.row));
  endtask

  task automatic cfg(logic [1:0] sel, int val);
    cfg_we = 1; cfg_sel = sel; cfg_data = CNT_W'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // run one frame, comparing every cycle; poke_at >= 0 issues ignored inputs
  task automatic run_frame(string req, bit use_chain, bit exp_chain, int poke_at);
    int idx = 0;
    if (use_chain) chain_in = 1; else start = 1;
    @(negedge clk);
    chain_in = 0; start = 0;
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      cmp(req, e);
      cfg_we = 0; start = 0;
      if (idx == poke_at) begin
        // R7: write attempt and restart attempt while busy
        cfg_we = 1; cfg_sel = 2'd2; cfg_data = 4'd9; start = 1;
      end
      idx++;
      @(negedge clk);
    end
    cfg_we = 0; start = 0;
    // R6: end pulse and busy fall
    chk("R6", !busy && frame_done == !exp_chain && chain_out == exp_chain,
        $sformatf("busy=%0b done=%0b chain=%0b", busy, frame_done, chain_out),
        $sformatf("busy=0 done=%0b chain=%0b", !exp_chain, exp_chain));
    @(negedge clk);
    chk("R6", !frame_done && !chain_out,
        $sformatf("done=%0b chain=%0b", frame_done, chain_out), "done=0 chain=0");
  endtask

  task automatic dstep();
    ext_step = 1;
    @(negedge clk);
    ext_step = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", gate_on == '0 && clear_on == '0 && !busy && !sample_pre &&
              !sample_post && !frame_done && !chain_out && row_idx == '0,
        $sformatf("g=%b c=%b busy=%0b row=%0d", gate_on, clear_on, busy, row_idx),
        "all zero");
    @(negedge clk);

    // R1 R3 R4 R5: default lengths (all 0), ascending, no hand-off
    dir_down = 0; chain_en = 0;
    build(0, 0, 0, 0, 0);
    run_frame("R3", 0, 0, -1);

    // R3: program lengths, descending via chain_in, hand-off (R4 R5 R6), pokes (R7)
    cfg(2'd0, 2); cfg(2'd1, 1); cfg(2'd2, 3); cfg(2'd3, 0);
    dir_down = 1; chain_en = 1;
    build(1, 2, 1, 3, 0);
    run_frame("R4", 1, 1, 10);

    // R7: lengths unchanged after the busy write; ascending, gap length 2
    cfg(2'd3, 2);
    dir_down = 0; chain_en = 0;
    build(0, 2, 1, 3, 2);
    run_frame("R7", 0, 0, 40);

    // R8: direct mode
    mode_direct = 1; dir_down = 0;
    start = 1; @(negedge clk); start = 0; mode_direct = 0;
    for (int i = 0; i < 5; i++) begin
      cmp("R8", '{0, 1, 0, 0, 0});
      @(negedge clk);
    end
    dstep(); cmp("R8", '{0, 1, 0, 1, 0});
    @(negedge clk); cmp("R8", '{0, 1, 0, 1, 0});
    dstep(); cmp("R8", '{0, 1, 1, 0, 0});
    dstep(); cmp("R8", '{0, 1, 0, 0, 1});
    dstep(); cmp("R8", '{0, 0, 0, 0, 0});
    @(negedge clk); @(negedge clk); cmp("R8", '{0, 0, 0, 0, 0});
    dstep(); cmp("R8", '{1, 1, 0, 0, 0});
    for (int r = 1; r < ROWS; r++) begin
      for (int s = 0; s < 5; s++) dstep();
    end
    chk("R8", !busy && frame_done,
        $sformatf("busy=%0b done=%0b", busy, frame_done), "busy=0 done=1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule